// File: doc/BRIEF.md
# Burst Type Error Responder

This block sits at the slave edge of a memory-mapped AXI4 bridge, between an upstream master and the logic that turns requests into link traffic. It inspects the burst type of every read and write address request. Incrementing bursts pass straight through to a simplified downstream request channel, and their data and responses flow through the block unchanged. Any other burst type is never forwarded: the block accepts the request itself and completes it with error responses.

An offending read is answered with one error beat per requested beat, with the final beat marked last. An offending write has all of its data beats accepted and thrown away, then gets a single error write response. Each offending request raises a one-cycle interrupt pulse, with separate bits for the read and write directions. Write data is steered to the downstream side or to the drain in the order the write addresses were accepted. Error read bursts are merged into the read data stream only between downstream bursts, so bursts are never interleaved.

Top module: `burst_guard`

## Requirements
- R1: Only burst code 2'b01 (incrementing) is forwarded; a request with code 2'b00, 2'b10 or 2'b11 never raises d_ar_valid or d_aw_valid.
- R2: A legal read or write address request is presented downstream in the same cycle with id, address and length unchanged, and the slave-side ready follows the downstream ready (for writes also gated by R6).
- R3: An illegal read request is accepted whenever no error read is pending, whatever the downstream ready; it is answered with exactly len+1 read beats, each with resp 2'b10 and the request's id, with last set only on the final beat.
- R4: Every data beat of an illegal write is accepted and never presented downstream; exactly one write response with resp 2'b10 and the request's id follows, and only after the beat with last has been accepted.
- R5: Bit 0 of irq_bad_burst goes high for exactly one cycle, the cycle after an illegal read address handshake; bit 1 does the same for an illegal write address handshake.
- R6: Write data beats are routed in write address acceptance order through a queue of WQ_DEPTH entries; the write address ready is low while the queue is full, write data ready is low while it is empty, and legal write beats are forwarded with data and last unchanged.
- R7: Downstream read beats and write responses reach the slave side with id, data, resp and last unchanged; an error read burst never starts while a downstream read burst is partly delivered.
- R8: Once the slave-side read or write response valid is shown without ready, valid, id, resp and last stay unchanged until the handshake.
- R9: After reset no slave-side response is valid, no request is forwarded and the interrupt bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_ar_valid | input | 1 | Read address valid from master |
| s_ar_ready | output | 1 | Read address ready to master |
| s_ar_id | input | ID_W | Read id |
| s_ar_addr | input | ADDR_W | Read address |
| s_ar_len | input | LEN_W | Read beats minus one |
| s_ar_burst | input | 2 | Read burst type |
| s_r_valid | output | 1 | Read data valid |
| s_r_ready | input | 1 | Read data ready |
| s_r_id | output | ID_W | Read data id |
| s_r_data | output | DATA_W | Read data |
| s_r_resp | output | 2 | Read response code |
| s_r_last | output | 1 | Final read beat |
| s_aw_valid | input | 1 | Write address valid |
| s_aw_ready | output | 1 | Write address ready |
| s_aw_id | input | ID_W | Write id |
| s_aw_addr | input | ADDR_W | Write address |
| s_aw_len | input | LEN_W | Write beats minus one |
| s_aw_burst | input | 2 | Write burst type |
| s_w_valid | input | 1 | Write data valid |
| s_w_ready | output | 1 | Write data ready |
| s_w_data | input | DATA_W | Write data |
| s_w_last | input | 1 | Final write beat |
| s_b_valid | output | 1 | Write response valid |
| s_b_ready | input | 1 | Write response ready |
| s_b_id | output | ID_W | Write response id |
| s_b_resp | output | 2 | Write response code |
| d_ar_valid | output | 1 | Forwarded read request valid |
| d_ar_ready | input | 1 | Forwarded read request ready |
| d_ar_id | output | ID_W | Forwarded read id |
| d_ar_addr | output | ADDR_W | Forwarded read address |
| d_ar_len | output | LEN_W | Forwarded read length |
| d_r_valid | input | 1 | Downstream read beat valid |
| d_r_ready | output | 1 | Downstream read beat ready |
| d_r_id | input | ID_W | Downstream read id |
| d_r_data | input | DATA_W | Downstream read data |
| d_r_resp | input | 2 | Downstream read response |
| d_r_last | input | 1 | Downstream final beat |
| d_aw_valid | output | 1 | Forwarded write request valid |
| d_aw_ready | input | 1 | Forwarded write request ready |
| d_aw_id | output | ID_W | Forwarded write id |
| d_aw_addr | output | ADDR_W | Forwarded write address |
| d_aw_len | output | LEN_W | Forwarded write length |
| d_w_valid | output | 1 | Forwarded write data valid |
| d_w_ready | input | 1 | Forwarded write data ready |
| d_w_data | output | DATA_W | Forwarded write data |
| d_w_last | output | 1 | Forwarded final write beat |
| d_b_valid | input | 1 | Downstream write response valid |
| d_b_ready | output | 1 | Downstream write response ready |
| d_b_id | input | ID_W | Downstream write response id |
| d_b_resp | input | 2 | Downstream write response code |
| irq_bad_burst | output | 2 | Illegal burst pulses, bit 0 read, bit 1 write |

## Verification
The bench builds the block with 4-bit lengths, 4-bit ids, 16-bit data and a write route queue of only two entries. With that configuration every burst code is swept against every length from one to four beats, with and without response backpressure, in both directions. The two-entry queue lets a short sequence fill it, which exposes the full-queue stall and the in-order steering of a legal write followed by a dropped one. A directed case injects an illegal read while a two-beat downstream burst is half delivered, to show that the error burst waits for the downstream last beat.

// File: rtl/burst_guard_pkg.sv
package burst_guard_pkg;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    function automatic logic burst_is_legal(input logic [1:0] code);
        return code == BT_INCR;
    endfunction

endpackage

// File: rtl/bg_route_fifo.sv
module bg_route_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp           = ptr_next(st_q.wp);
        end
        if (pop) begin
            st_d.rp = ptr_next(st_q.rp);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/bg_rd_path.sv
module bg_rd_path
    import burst_guard_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_ar_valid,
    output logic              s_ar_ready,
    input  logic [ID_W-1:0]   s_ar_id,
    input  logic [ADDR_W-1:0] s_ar_addr,
    input  logic [LEN_W-1:0]  s_ar_len,
    input  logic [1:0]        s_ar_burst,
    output logic              s_r_valid,
    input  logic              s_r_ready,
    output logic [ID_W-1:0]   s_r_id,
    output logic [DATA_W-1:0] s_r_data,
    output logic [1:0]        s_r_resp,
    output logic              s_r_last,
    output logic              d_ar_valid,
    input  logic              d_ar_ready,
    output logic [ID_W-1:0]   d_ar_id,
    output logic [ADDR_W-1:0] d_ar_addr,
    output logic [LEN_W-1:0]  d_ar_len,
    input  logic              d_r_valid,
    output logic              d_r_ready,
    input  logic [ID_W-1:0]   d_r_id,
    input  logic [DATA_W-1:0] d_r_data,
    input  logic [1:0]        d_r_resp,
    input  logic              d_r_last,
    output logic              bad_rd_accept
);
    typedef struct packed {
        logic             err_active;
        logic [ID_W-1:0]  err_id;
        logic [LEN_W-1:0] err_left;
        logic             err_in_burst;
        logic             ds_in_burst;
        logic             lock;
        logic             lock_err;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   legal;
    logic   sel_err;
    logic   err_hs;
    logic   ds_hs;

    always_comb begin
        legal         = burst_is_legal(s_ar_burst);
        d_ar_valid    = s_ar_valid && legal;
        d_ar_id       = s_ar_id;
        d_ar_addr     = s_ar_addr;
        d_ar_len      = s_ar_len;
        s_ar_ready    = legal ? d_ar_ready : !st_q.err_active;
        bad_rd_accept = s_ar_valid && !legal && !st_q.err_active;

        if (st_q.lock)              sel_err = st_q.lock_err;
        else if (st_q.ds_in_burst)  sel_err = 1'b0;
        else if (st_q.err_in_burst) sel_err = 1'b1;
        else                        sel_err = st_q.err_active;

        if (sel_err) begin
            s_r_valid = st_q.err_active;
            s_r_id    = st_q.err_id;
            s_r_data  = '0;
            s_r_resp  = RESP_SLVERR;
            s_r_last  = (st_q.err_left == '0);
        end else begin
            s_r_valid = d_r_valid;
            s_r_id    = d_r_id;
            s_r_data  = d_r_data;
            s_r_resp  = d_r_resp;
            s_r_last  = d_r_last;
        end
        d_r_ready = s_r_ready && !sel_err;
        err_hs    = sel_err && st_q.err_active && s_r_ready;
        ds_hs     = !sel_err && d_r_valid && s_r_ready;

        st_d = st_q;
        if (bad_rd_accept) begin
            st_d.err_active   = 1'b1;
            st_d.err_id       = s_ar_id;
            st_d.err_left     = s_ar_len;
            st_d.err_in_burst = 1'b0;
        end
        if (err_hs) begin
            if (st_q.err_left == '0) begin
                st_d.err_active   = 1'b0;
                st_d.err_in_burst = 1'b0;
            end else begin
                st_d.err_left     = st_q.err_left - LEN_W'(1);
                st_d.err_in_burst = 1'b1;
            end
        end
        if (ds_hs) begin
            st_d.ds_in_burst = !d_r_last;
        end
        st_d.lock     = s_r_valid && !s_r_ready;
        st_d.lock_err = sel_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bg_wr_path.sv
module bg_wr_path
    import burst_guard_pkg::*;
#(
    parameter int ID_W     = 4,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 8,
    parameter int WQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_aw_valid,
    output logic              s_aw_ready,
    input  logic [ID_W-1:0]   s_aw_id,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [LEN_W-1:0]  s_aw_len,
    input  logic [1:0]        s_aw_burst,
    input  logic              s_w_valid,
    output logic              s_w_ready,
    input  logic [DATA_W-1:0] s_w_data,
    input  logic              s_w_last,
    output logic              s_b_valid,
    input  logic              s_b_ready,
    output logic [ID_W-1:0]   s_b_id,
    output logic [1:0]        s_b_resp,
    output logic              d_aw_valid,
    input  logic              d_aw_ready,
    output logic [ID_W-1:0]   d_aw_id,
    output logic [ADDR_W-1:0] d_aw_addr,
    output logic [LEN_W-1:0]  d_aw_len,
    output logic              d_w_valid,
    input  logic              d_w_ready,
    output logic [DATA_W-1:0] d_w_data,
    output logic              d_w_last,
    input  logic              d_b_valid,
    output logic              d_b_ready,
    input  logic [ID_W-1:0]   d_b_id,
    input  logic [1:0]        d_b_resp,
    output logic              bad_wr_accept
);
    localparam int RT_W = ID_W + 1;

    typedef struct packed {
        logic            berr_pend;
        logic [ID_W-1:0] berr_id;
        logic            lock;
        logic            lock_err;
    } wr_st_t;

    wr_st_t          st_d, st_q;
    logic            legal;
    logic            q_push, q_pop, q_empty, q_full;
    logic [RT_W-1:0] q_in, q_head;
    logic            head_drop;
    logic [ID_W-1:0] head_id;
    logic            w_hs;
    logic            sel_err;
    logic            berr_hs;

    bg_route_fifo #(.W(RT_W), .DEPTH(WQ_DEPTH)) i_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_in),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    always_comb begin
        legal         = burst_is_legal(s_aw_burst);
        d_aw_valid    = s_aw_valid && legal && !q_full;
        d_aw_id       = s_aw_id;
        d_aw_addr     = s_aw_addr;
        d_aw_len      = s_aw_len;
        s_aw_ready    = !q_full && (legal ? d_aw_ready : 1'b1);
        q_push        = s_aw_valid && s_aw_ready;
        q_in          = {!legal, s_aw_id};
        bad_wr_accept = q_push && !legal;

        head_drop = q_head[RT_W-1];
        head_id   = q_head[ID_W-1:0];
        d_w_valid = s_w_valid && !q_empty && !head_drop;
        d_w_data  = s_w_data;
        d_w_last  = s_w_last;
        s_w_ready = !q_empty && (head_drop ? !st_q.berr_pend : d_w_ready);
        w_hs      = s_w_valid && s_w_ready;
        q_pop     = w_hs && s_w_last;

        sel_err = st_q.lock ? st_q.lock_err : st_q.berr_pend;
        if (sel_err) begin
            s_b_valid = st_q.berr_pend;
            s_b_id    = st_q.berr_id;
            s_b_resp  = RESP_SLVERR;
        end else begin
            s_b_valid = d_b_valid;
            s_b_id    = d_b_id;
            s_b_resp  = d_b_resp;
        end
        d_b_ready = s_b_ready && !sel_err;
        berr_hs   = sel_err && st_q.berr_pend && s_b_ready;

        st_d = st_q;
        if (berr_hs) begin
            st_d.berr_pend = 1'b0;
        end
        if (q_pop && head_drop) begin
            st_d.berr_pend = 1'b1;
            st_d.berr_id   = head_id;
        end
        st_d.lock     = s_b_valid && !s_b_ready;
        st_d.lock_err = sel_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/burst_guard.sv
module burst_guard
    import burst_guard_pkg::*;
#(
    parameter int ID_W     = 4,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 8,
    parameter int WQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_ar_valid,
    output logic              s_ar_ready,
    input  logic [ID_W-1:0]   s_ar_id,
    input  logic [ADDR_W-1:0] s_ar_addr,
    input  logic [LEN_W-1:0]  s_ar_len,
    input  logic [1:0]        s_ar_burst,
    output logic              s_r_valid,
    input  logic              s_r_ready,
    output logic [ID_W-1:0]   s_r_id,
    output logic [DATA_W-1:0] s_r_data,
    output logic [1:0]        s_r_resp,
    output logic              s_r_last,
    input  logic              s_aw_valid,
    output logic              s_aw_ready,
    input  logic [ID_W-1:0]   s_aw_id,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [LEN_W-1:0]  s_aw_len,
    input  logic [1:0]        s_aw_burst,
    input  logic              s_w_valid,
    output logic              s_w_ready,
    input  logic [DATA_W-1:0] s_w_data,
    input  logic              s_w_last,
    output logic              s_b_valid,
    input  logic              s_b_ready,
    output logic [ID_W-1:0]   s_b_id,
    output logic [1:0]        s_b_resp,
    output logic              d_ar_valid,
    input  logic              d_ar_ready,
    output logic [ID_W-1:0]   d_ar_id,
    output logic [ADDR_W-1:0] d_ar_addr,
    output logic [LEN_W-1:0]  d_ar_len,
    input  logic              d_r_valid,
    output logic              d_r_ready,
    input  logic [ID_W-1:0]   d_r_id,
    input  logic [DATA_W-1:0] d_r_data,
    input  logic [1:0]        d_r_resp,
    input  logic              d_r_last,
    output logic              d_aw_valid,
    input  logic              d_aw_ready,
    output logic [ID_W-1:0]   d_aw_id,
    output logic [ADDR_W-1:0] d_aw_addr,
    output logic [LEN_W-1:0]  d_aw_len,
    output logic              d_w_valid,
    input  logic              d_w_ready,
    output logic [DATA_W-1:0] d_w_data,
    output logic              d_w_last,
    input  logic              d_b_valid,
    output logic              d_b_ready,
    input  logic [ID_W-1:0]   d_b_id,
    input  logic [1:0]        d_b_resp,
    output logic [1:0]        irq_bad_burst
);
    typedef struct packed {
        logic [1:0] irq;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    bad_rd_accept;
    logic    bad_wr_accept;

    bg_rd_path #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
    ) i_rd (
        .clk(clk), .rst_n(rst_n),
        .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .s_ar_id(s_ar_id),
        .s_ar_addr(s_ar_addr), .s_ar_len(s_ar_len), .s_ar_burst(s_ar_burst),
        .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_id(s_r_id),
        .s_r_data(s_r_data), .s_r_resp(s_r_resp), .s_r_last(s_r_last),
        .d_ar_valid(d_ar_valid), .d_ar_ready(d_ar_ready), .d_ar_id(d_ar_id),
        .d_ar_addr(d_ar_addr), .d_ar_len(d_ar_len),
        .d_r_valid(d_r_valid), .d_r_ready(d_r_ready), .d_r_id(d_r_id),
        .d_r_data(d_r_data), .d_r_resp(d_r_resp), .d_r_last(d_r_last),
        .bad_rd_accept(bad_rd_accept)
    );

    bg_wr_path #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
        .WQ_DEPTH(WQ_DEPTH)
    ) i_wr (
        .clk(clk), .rst_n(rst_n),
        .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready), .s_aw_id(s_aw_id),
        .s_aw_addr(s_aw_addr), .s_aw_len(s_aw_len), .s_aw_burst(s_aw_burst),
        .s_w_valid(s_w_valid), .s_w_ready(s_w_ready), .s_w_data(s_w_data),
        .s_w_last(s_w_last),
        .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_id(s_b_id),
        .s_b_resp(s_b_resp),
        .d_aw_valid(d_aw_valid), .d_aw_ready(d_aw_ready), .d_aw_id(d_aw_id),
        .d_aw_addr(d_aw_addr), .d_aw_len(d_aw_len),
        .d_w_valid(d_w_valid), .d_w_ready(d_w_ready), .d_w_data(d_w_data),
        .d_w_last(d_w_last),
        .d_b_valid(d_b_valid), .d_b_ready(d_b_ready), .d_b_id(d_b_id),
        .d_b_resp(d_b_resp),
        .bad_wr_accept(bad_wr_accept)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = {bad_wr_accept, bad_rd_accept};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_bad_burst = st_q.irq;

endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            s_ar_valid,
    input logic            s_ar_ready,
    input logic [1:0]      s_ar_burst,
    input logic            d_ar_valid,
    input logic [1:0]      s_aw_burst,
    input logic            d_aw_valid,
    input logic            s_r_valid,
    input logic            s_r_ready,
    input logic [ID_W-1:0] s_r_id,
    input logic [1:0]      s_r_resp,
    input logic            s_r_last,
    input logic            s_b_valid,
    input logic            s_b_ready,
    input logic [ID_W-1:0] s_b_id,
    input logic [1:0]      s_b_resp,
    input logic [1:0]      irq_bad_burst
);
    assert_ar_incr_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        d_ar_valid |-> s_ar_burst == 2'b01);

    assert_aw_incr_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        d_aw_valid |-> s_aw_burst == 2'b01);

    assert_irq_after_bad_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ar_valid && s_ar_ready && s_ar_burst != 2'b01) |=> irq_bad_burst[0]);

    assert_irq_read_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_bad_burst[0] |=> !irq_bad_burst[0]);

    assert_r_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_r_valid && !s_r_ready) |=>
            (s_r_valid && $stable(s_r_id) && $stable(s_r_resp) && $stable(s_r_last)));

    assert_b_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_b_valid && !s_b_ready) |=> (s_b_valid && $stable(s_b_id) && $stable(s_b_resp)));
endmodule

bind burst_guard bg_checker #(.ID_W(ID_W)) i_bg_checker (
    .clk(clk), .rst_n(rst_n),
    .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .s_ar_burst(s_ar_burst),
    .d_ar_valid(d_ar_valid), .s_aw_burst(s_aw_burst), .d_aw_valid(d_aw_valid),
    .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_id(s_r_id),
    .s_r_resp(s_r_resp), .s_r_last(s_r_last),
    .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_id(s_b_id),
    .s_b_resp(s_b_resp), .irq_bad_burst(irq_bad_burst)
);

// File: tb/test_burst_guard.sv
module test_burst_guard;
    localparam int ID_W = 4, ADDR_W = 16, DATA_W = 16, LEN_W = 4, WQ_DEPTH = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic s_ar_valid = 0, s_ar_ready; logic [ID_W-1:0] s_ar_id = 0;
    logic [ADDR_W-1:0] s_ar_addr = 0; logic [LEN_W-1:0] s_ar_len = 0; logic [1:0] s_ar_burst = 0;
    logic s_r_valid, s_r_ready = 0; logic [ID_W-1:0] s_r_id; logic [DATA_W-1:0] s_r_data;
    logic [1:0] s_r_resp; logic s_r_last;
    logic s_aw_valid = 0, s_aw_ready; logic [ID_W-1:0] s_aw_id = 0;
    logic [ADDR_W-1:0] s_aw_addr = 0; logic [LEN_W-1:0] s_aw_len = 0; logic [1:0] s_aw_burst = 0;
    logic s_w_valid = 0, s_w_ready; logic [DATA_W-1:0] s_w_data = 0; logic s_w_last = 0;
    logic s_b_valid, s_b_ready = 0; logic [ID_W-1:0] s_b_id; logic [1:0] s_b_resp;
    logic d_ar_valid, d_ar_ready = 0; logic [ID_W-1:0] d_ar_id; logic [ADDR_W-1:0] d_ar_addr;
    logic [LEN_W-1:0] d_ar_len;
    logic d_r_valid = 0, d_r_ready; logic [ID_W-1:0] d_r_id = 0; logic [DATA_W-1:0] d_r_data = 0;
    logic [1:0] d_r_resp = 0; logic d_r_last = 0;
    logic d_aw_valid, d_aw_ready = 0; logic [ID_W-1:0] d_aw_id; logic [ADDR_W-1:0] d_aw_addr;
    logic [LEN_W-1:0] d_aw_len;
    logic d_w_valid, d_w_ready = 0; logic [DATA_W-1:0] d_w_data; logic d_w_last;
    logic d_b_valid = 0, d_b_ready; logic [ID_W-1:0] d_b_id = 0; logic [1:0] d_b_resp = 0;
    logic [1:0] irq_bad_burst;

    int vectors = 0, fails = 0, irq_rd_n = 0, irq_wr_n = 0;

    always #5 clk = ~clk;

    burst_guard #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                  .WQ_DEPTH(WQ_DEPTH)) i_burst_guard (.*);

    always @(negedge clk) if (rst_n) begin
        irq_rd_n += int'(irq_bad_burst[0]);
        irq_wr_n += int'(irq_bad_burst[1]);
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic rd_case(input logic [1:0] burst, input int len, input int id, input bit stall);
        int irq0 = irq_rd_n, beat = 0, cyc = 0;
        bit legal = (burst == 2'b01), held = 0;
        logic [ID_W-1:0] h_id; logic [1:0] h_resp; logic h_last;
        @(negedge clk);
        s_ar_valid = 1; s_ar_burst = burst; s_ar_len = LEN_W'(len); s_ar_id = ID_W'(id);
        s_ar_addr = ADDR_W'(16'h1000 + id * 16 + len); d_ar_ready = 1; #1;
        if (legal) begin
            chk("R2", "d_ar_valid", d_ar_valid, 1);
            chk("R2", "d_ar_id", d_ar_id, id);
            chk("R2", "d_ar_addr", d_ar_addr, 16'h1000 + id * 16 + len);
            chk("R2", "d_ar_len", d_ar_len, len);
        end else chk("R1", "d_ar_valid on bad burst", d_ar_valid, 0);
        chk("R3", "s_ar_ready", s_ar_ready, 1);
        @(negedge clk); s_ar_valid = 0;
        while (beat <= len && cyc < 100) begin
            s_r_ready = stall ? cyc[0] : 1'b1;
            if (legal) begin
                d_r_valid = 1; d_r_id = ID_W'(id); d_r_resp = 2'b00;
                d_r_data = DATA_W'(16'hA000 + id * 256 + beat); d_r_last = (beat == len);
            end
            #1;
            if (held) begin
                chk("R8", "r valid held", s_r_valid, 1);
                chk("R8", "r id held", s_r_id, h_id);
                chk("R8", "r resp held", s_r_resp, h_resp);
                chk("R8", "r last held", s_r_last, h_last);
            end
            held = s_r_valid && !s_r_ready;
            h_id = s_r_id; h_resp = s_r_resp; h_last = s_r_last;
            if (legal) chk("R7", "d_r_ready follows", d_r_ready, s_r_ready);
            if (s_r_valid && s_r_ready) begin
                if (legal) begin
                    chk("R7", "r data", s_r_data, 16'hA000 + id * 256 + beat);
                    chk("R7", "r resp", s_r_resp, 0);
                end else chk("R3", "r resp", s_r_resp, 2'b10);
                chk(legal ? "R7" : "R3", "r id", s_r_id, id);
                chk(legal ? "R7" : "R3", "r last", s_r_last, beat == len);
                beat++;
            end
            @(negedge clk); cyc++;
        end
        d_r_valid = 0; d_r_last = 0; s_r_ready = 1; #1;
        chk("R3", "beat count", beat, len + 1);
        chk("R3", "no extra beat", s_r_valid, 0);
        @(negedge clk);
        chk("R5", "read irq pulses", irq_rd_n - irq0, legal ? 0 : 1);
    endtask

    task automatic wr_case(input logic [1:0] burst, input int len, input int id, input bit stall);
        int irq1 = irq_wr_n, beat = 0, cyc = 0, got = 0;
        bit legal = (burst == 2'b01), held = 0;
        logic [ID_W-1:0] h_id; logic [1:0] h_resp;
        @(negedge clk);
        s_aw_valid = 1; s_aw_burst = burst; s_aw_len = LEN_W'(len); s_aw_id = ID_W'(id);
        s_aw_addr = ADDR_W'(16'h2000 + id * 16 + len); d_aw_ready = 1; #1;
        if (legal) begin
            chk("R2", "d_aw_valid", d_aw_valid, 1);
            chk("R2", "d_aw_id", d_aw_id, id);
            chk("R2", "d_aw_addr", d_aw_addr, 16'h2000 + id * 16 + len);
            chk("R2", "d_aw_len", d_aw_len, len);
        end else chk("R1", "d_aw_valid on bad burst", d_aw_valid, 0);
        chk("R2", "s_aw_ready", s_aw_ready, 1);
        @(negedge clk); s_aw_valid = 0;
        while (beat <= len && cyc < 100) begin
            s_w_valid = 1; s_w_data = DATA_W'(16'hB000 + id * 256 + beat); s_w_last = (beat == len);
            d_w_ready = stall ? cyc[0] : 1'b1; #1;
            if (legal) begin
                chk("R6", "d_w_valid", d_w_valid, 1);
                chk("R6", "d_w_data", d_w_data, 16'hB000 + id * 256 + beat);
                chk("R6", "d_w_last", d_w_last, beat == len);
            end else begin
                chk("R4", "dropped beat hidden", d_w_valid, 0);
                chk("R4", "no early b", s_b_valid, 0);
                chk("R4", "drop accepted", s_w_ready, 1);
            end
            if (s_w_ready) beat++;
            @(negedge clk); cyc++;
        end
        s_w_valid = 0; s_w_last = 0; cyc = 0;
        while (got == 0 && cyc < 100) begin
            if (legal) begin d_b_valid = 1; d_b_id = ID_W'(id); d_b_resp = 2'b00; end
            s_b_ready = stall ? cyc[0] : 1'b1; #1;
            if (held) begin
                chk("R8", "b valid held", s_b_valid, 1);
                chk("R8", "b id held", s_b_id, h_id);
                chk("R8", "b resp held", s_b_resp, h_resp);
            end
            held = s_b_valid && !s_b_ready; h_id = s_b_id; h_resp = s_b_resp;
            if (s_b_valid && s_b_ready) begin
                chk(legal ? "R7" : "R4", "b id", s_b_id, id);
                chk(legal ? "R7" : "R4", "b resp", s_b_resp, legal ? 2'b00 : 2'b10);
                got++;
            end
            @(negedge clk); cyc++;
        end
        d_b_valid = 0; #1;
        chk("R4", "b received", got, 1);
        chk("R4", "single b", s_b_valid, 0);
        @(negedge clk);
        chk("R5", "write irq pulses", irq_wr_n - irq1, legal ? 0 : 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int irq_before;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R9", "r valid", s_r_valid, 0);
        chk("R9", "b valid", s_b_valid, 0);
        chk("R9", "d_ar_valid", d_ar_valid, 0);
        chk("R9", "d_aw_valid", d_aw_valid, 0);
        chk("R9", "irq", irq_bad_burst, 0);
        chk("R6", "w ready with empty queue", s_w_ready, 0);

        for (int b = 0; b < 4; b++)
            for (int l = 0; l < 4; l++)
                for (int s = 0; s < 2; s++) begin
                    rd_case(2'(b), l, (b * 4 + l) % 16, s[0]);
                    wr_case(2'(b), l, (b * 4 + l + 5) % 16, s[0]);
                end

        // R6: order of steering, queue full
        irq_before = irq_wr_n;
        @(negedge clk);
        s_aw_valid = 1; s_aw_burst = 2'b01; s_aw_id = 1; s_aw_len = 0; d_aw_ready = 1; #1;
        chk("R6", "aw1 ready", s_aw_ready, 1);
        @(negedge clk); s_aw_burst = 2'b10; s_aw_id = 2; #1;
        chk("R6", "aw2 ready", s_aw_ready, 1);
        @(negedge clk); s_aw_burst = 2'b01; s_aw_id = 3; #1;
        chk("R6", "aw ready when full", s_aw_ready, 0);
        chk("R6", "no forward when full", d_aw_valid, 0);
        @(negedge clk); s_aw_valid = 0;
        s_w_valid = 1; s_w_data = 16'h0011; s_w_last = 1; d_w_ready = 1; #1;
        chk("R6", "first beat forwarded", d_w_valid, 1);
        chk("R6", "first beat data", d_w_data, 16'h0011);
        @(negedge clk); s_w_data = 16'h0022; #1;
        chk("R6", "second beat dropped", d_w_valid, 0);
        chk("R6", "second beat accepted", s_w_ready, 1);
        @(negedge clk); s_w_valid = 0; s_w_last = 0; s_b_ready = 1; #1;
        chk("R4", "err b valid", s_b_valid, 1);
        chk("R4", "err b id", s_b_id, 2);
        chk("R4", "err b resp", s_b_resp, 2'b10);
        @(negedge clk); d_b_valid = 1; d_b_id = 1; d_b_resp = 2'b00; #1;
        chk("R7", "ds b id", s_b_id, 1);
        chk("R7", "ds b resp", s_b_resp, 0);
        @(negedge clk); d_b_valid = 0;
        @(negedge clk);
        chk("R5", "order test irq", irq_wr_n - irq_before, 1);

        // R7: error burst waits for downstream burst to finish
        @(negedge clk);
        s_ar_valid = 1; s_ar_burst = 2'b01; s_ar_id = 3; s_ar_len = 1; d_ar_ready = 1;
        @(negedge clk);
        s_ar_burst = 2'b00; s_ar_id = 5; s_ar_len = 0; d_ar_ready = 0;
        d_r_valid = 1; d_r_id = 3; d_r_data = 16'hAAAA; d_r_resp = 0; d_r_last = 0; s_r_ready = 1; #1;
        chk("R7", "ds beat 0 data", s_r_data, 16'hAAAA);
        chk("R3", "bad ar accepted", s_ar_ready, 1);
        @(negedge clk); s_ar_valid = 0; d_r_valid = 0; #1;
        chk("R7", "no error mid burst", s_r_valid, 0);
        @(negedge clk); d_r_valid = 1; d_r_data = 16'hBBBB; d_r_last = 1; #1;
        chk("R7", "ds beat 1 data", s_r_data, 16'hBBBB);
        chk("R7", "ds beat 1 id", s_r_id, 3);
        chk("R7", "ds beat 1 last", s_r_last, 1);
        @(negedge clk); d_r_valid = 0; d_r_last = 0; #1;
        chk("R3", "error beat valid", s_r_valid, 1);
        chk("R3", "error beat id", s_r_id, 5);
        chk("R3", "error beat resp", s_r_resp, 2'b10);
        chk("R3", "error beat last", s_r_last, 1);
        @(negedge clk); #1;
        chk("R3", "error burst done", s_r_valid, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule